// File: doc/BRIEF.md
# Flash ECC Engine Control Front-End

This block is the register and sequencing front-end of a flash error-correction engine. It has two independent channels, one for encoding and one for decoding, and both are reached through a simple 32-bit memory-mapped register bus. Each channel has the following registers:

- a run control register;
- a configuration word;
- an idle flag;
- an interrupt-enable pair;
- a clear-on-read interrupt status flag.

The decode channel also has a per-sector completion bitmask.

The real correction datapath is not part of this block. Each channel drives a step engine that stands in for it. Once started, the step engine produces one step-complete strobe per configured sector. The time between strobes is derived from the message length held in the configuration word.

The configuration word is split into four fields:

- a strength index;
- an operating mode;
- a step count;
- a message length in bits.

For a decode, software programs the message length as the data bits plus the strength times 14 parity bits. For an encode, software programs the data bits only. Interrupts are raised either once per step or once per page, and are presented on one level-sensitive output.

Top module: `eccFront`

## Requirements
- R1: After reset, these registers read 0: both control registers, both configuration words, both interrupt-enable registers, both status registers and the decode done mask. Both idle registers read 1 in bit 0, and `irq` is 0.
- R2: Writing 1 to bit 0 of an idle channel's control register (encode 0x000, decode 0x100) starts that channel. The idle bit 0 (encode 0x00C, decode 0x10C) reads 0 from the next cycle. It reads 1 again exactly steps×lat cycles after the write edge, where steps = cfg[10:8]+1 and lat = 2 + (cfg[29:16] >> 6).
- R3: Writing 0 to a busy channel's control register stops it. The channel is idle on the next cycle and produces no further step events.
- R4: Configuration words are held at 0x004 (encode) and 0x104 (decode) and read back as stored. The fields are: strength index in bits 4:0, mode in bit 5, step count minus one in bits 10:8, and message bits in bits 29:16. The decode word also keeps a correction field in bits 13:12 and an empty-page detect enable in bit 31. In the encode word those decode-only bits, and all unlisted bits, read 0.
- R5: A configuration write whose strength index (bits 4:0) is 20 or above is ignored.
- R6: A configuration write to a channel while that channel is busy is ignored.
- R7: The interrupt-enable registers are at 0x080 (encode) and 0x200 (decode). With enable bit 0 set and per-step operation, every step completion sets the channel's status flag. `irq` is the OR of the flags that are both pending and enabled.
- R8: Page mode applies when interrupt-enable bit 1 is 1 and configuration mode bit 5 is 0. In page mode, only the final step sets the status flag. With mode bit 5 = 1, bit 1 has no effect and every step sets the flag.
- R9: Reading a status register (encode 0x084, decode 0x204) returns the flag in bit 0 and clears it. If a setting step event occurs in the cycle of the read, the read returns 0 and the flag stays set.
- R10: The decode done register 0x124 sets bit k when decode step k (numbered from 0) completes. Reading it returns the mask and clears both the mask and the decode status flag. A step event in the same cycle as the read survives the clear.
- R11: With interrupt-enable bit 0 at 0, step completions leave the status flag at 0 and `irq` at 0.
- R12: The encode and decode channels start, run and finish independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe; clear-on-read effects take place at the clock edge |
| busAddr | input | 12 | Byte address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from busAddr while busRdEn is high |
| irq | output | 1 | Level interrupt, the OR of the enabled and pending status flags |

## Verification
A status flag can be set by a step completion and cleared by a bus read in the same cycle. The decode done mask faces the same collision. The bench counts the step engine's latency from the start edge and issues the clearing read so that it covers exactly the edge where a step completes. It then judges the outcome in three reads: the read itself must return the pre-edge value 0, a side-effect-free peek right after must show the flag or mask bit still set, and a second clearing read must return it and empty it.

// File: rtl/eccFrontPkg.sv
`timescale 1ns/1ps
package eccFrontPkg;
  parameter int ADDR_W    = 12;
  parameter int DATA_W    = 32;
  parameter int IDX_W     = 5;
  parameter int MODE_BIT  = 5;
  parameter int STEP_LSB  = 8;
  parameter int STEP_W    = 3;
  parameter int CORR_LSB  = 12;
  parameter int CORR_W    = 2;
  parameter int MSG_LSB   = 16;
  parameter int MSG_W     = 14;
  parameter int EMPTY_BIT = 31;
  parameter int NUM_CH    = 2;
  parameter int CH_ENC    = 0;
  parameter int CH_DEC    = 1;

  localparam int LAT_W     = MSG_W + 1;
  localparam int MAX_STEPS = 1 << STEP_W;

  localparam logic [ADDR_W-1:0] OFF_ENC_CTL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_ENC_CFG  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_ENC_IDLE = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_ENC_IEN  = 12'h080;
  localparam logic [ADDR_W-1:0] OFF_ENC_STA  = 12'h084;
  localparam logic [ADDR_W-1:0] OFF_DEC_CTL  = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_DEC_CFG  = 12'h104;
  localparam logic [ADDR_W-1:0] OFF_DEC_IDLE = 12'h10C;
  localparam logic [ADDR_W-1:0] OFF_DEC_DONE = 12'h124;
  localparam logic [ADDR_W-1:0] OFF_DEC_IEN  = 12'h200;
  localparam logic [ADDR_W-1:0] OFF_DEC_STA  = 12'h204;

  function automatic logic [DATA_W-1:0] fieldMask(input int lsb, input int w);
    return ((DATA_W'(1) << w) - DATA_W'(1)) << lsb;
  endfunction

  localparam logic [DATA_W-1:0] ENC_CFG_MASK =
    fieldMask(0, IDX_W) | fieldMask(MODE_BIT, 1) |
    fieldMask(STEP_LSB, STEP_W) | fieldMask(MSG_LSB, MSG_W);
  localparam logic [DATA_W-1:0] DEC_CFG_MASK =
    ENC_CFG_MASK | fieldMask(CORR_LSB, CORR_W) | fieldMask(EMPTY_BIT, 1);

  function automatic logic [ADDR_W-1:0] ctlOff(input int ch);
    return (ch == CH_DEC) ? OFF_DEC_CTL : OFF_ENC_CTL;
  endfunction
  function automatic logic [ADDR_W-1:0] cfgOff(input int ch);
    return (ch == CH_DEC) ? OFF_DEC_CFG : OFF_ENC_CFG;
  endfunction
  function automatic logic [ADDR_W-1:0] idleOff(input int ch);
    return (ch == CH_DEC) ? OFF_DEC_IDLE : OFF_ENC_IDLE;
  endfunction
  function automatic logic [ADDR_W-1:0] ienOff(input int ch);
    return (ch == CH_DEC) ? OFF_DEC_IEN : OFF_ENC_IEN;
  endfunction
  function automatic logic [ADDR_W-1:0] staOff(input int ch);
    return (ch == CH_DEC) ? OFF_DEC_STA : OFF_ENC_STA;
  endfunction

  // Strobes from the register side to one step engine.
  typedef struct packed {
    logic              start;
    logic              stop;
    logic [LAT_W-1:0]  lat;
    logic [STEP_W-1:0] lastIdx;
  } chanCmd_t;

  // Events from one step engine back to the register side.
  typedef struct packed {
    logic              busy;
    logic              stepDone;
    logic              lastStep;
    logic [STEP_W-1:0] stepIdx;
  } chanEvt_t;
endpackage

// File: rtl/eccStepEngine.sv
`timescale 1ns/1ps
module eccStepEngine
  import eccFrontPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  chanCmd_t cmd,
  output chanEvt_t evt
);
  logic              busy;
  logic [LAT_W-1:0]  cnt;
  logic [LAT_W-1:0]  latQ;
  logic [STEP_W-1:0] idx;
  logic [STEP_W-1:0] lastQ;
  logic              stepNow;

  // A step completes in the cycle whose counter shows 1; a stop that cycle suppresses it.
  assign stepNow = busy && (cnt == LAT_W'(1)) && !cmd.stop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      cnt   <= '0;
      latQ  <= '0;
      idx   <= '0;
      lastQ <= '0;
    end else if (cmd.stop) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (cmd.start) begin
        busy  <= 1'b1;
        cnt   <= cmd.lat;
        latQ  <= cmd.lat;
        idx   <= '0;
        lastQ <= cmd.lastIdx;
      end
    end else if (cnt == LAT_W'(1)) begin
      cnt <= latQ;
      if (idx == lastQ) busy <= 1'b0;
      else              idx  <= idx + STEP_W'(1);
    end else begin
      cnt <= cnt - LAT_W'(1);
    end
  end

  assign evt.busy     = busy;
  assign evt.stepDone = stepNow;
  assign evt.lastStep = stepNow && (idx == lastQ);
  assign evt.stepIdx  = idx;
endmodule

// File: rtl/eccRegCtrl.sv
`timescale 1ns/1ps
module eccRegCtrl
  import eccFrontPkg::*;
#(
  parameter int NUM_STRENGTHS = 20,
  parameter int BASE_LAT      = 2,
  parameter int LAT_SHIFT     = 6
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busWrEn,
  input  logic                           busRdEn,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busWrData,
  output logic [DATA_W-1:0]              busRdData,
  output logic                           irq,
  input  chanEvt_t [NUM_CH-1:0]          evtVec,
  output chanCmd_t [NUM_CH-1:0]          cmdVec,
  output logic [NUM_CH-1:0]              staVec,
  output logic [NUM_CH-1:0]              ienLoVec,
  output logic [NUM_CH-1:0][DATA_W-1:0]  cfgVec
);
  logic [NUM_CH-1:0]         ctlVec;
  logic [NUM_CH-1:0][1:0]    ienVec;
  logic [MAX_STEPS-1:0]      doneQ;
  logic                      rdDone;

  assign rdDone = busRdEn && (busAddr == OFF_DEC_DONE);

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    localparam logic [DATA_W-1:0] CFG_MASK = (c == CH_DEC) ? DEC_CFG_MASK : ENC_CFG_MASK;
    logic              wrCtl, wrCfg, wrIen, rdSta, clrSta, setSta, pageMode, idxOk;
    logic              ctlR, staR;
    logic [1:0]        ienR;
    logic [DATA_W-1:0] cfgR;
    logic [MSG_W-1:0]  msgBits;

    assign wrCtl    = busWrEn && (busAddr == ctlOff(c));
    assign wrCfg    = busWrEn && (busAddr == cfgOff(c));
    assign wrIen    = busWrEn && (busAddr == ienOff(c));
    assign rdSta    = busRdEn && (busAddr == staOff(c));
    assign clrSta   = rdSta || ((c == CH_DEC) && rdDone);
    assign idxOk    = 32'(busWrData[IDX_W-1:0]) < NUM_STRENGTHS;
    assign pageMode = ienR[1] && !cfgR[MODE_BIT];
    assign setSta   = ienR[0] && evtVec[c].stepDone && (!pageMode || evtVec[c].lastStep);
    assign msgBits  = cfgR[MSG_LSB +: MSG_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctlR <= 1'b0;
        cfgR <= '0;
        ienR <= '0;
        staR <= 1'b0;
      end else begin
        if (wrCtl) ctlR <= busWrData[0];
        if (wrCfg && idxOk && !evtVec[c].busy) cfgR <= busWrData & CFG_MASK;
        if (wrIen) ienR <= busWrData[1:0];
        staR <= setSta || (staR && !clrSta);
      end
    end

    assign cmdVec[c].start   = wrCtl && busWrData[0];
    assign cmdVec[c].stop    = wrCtl && !busWrData[0];
    assign cmdVec[c].lat     = LAT_W'(BASE_LAT) + LAT_W'(msgBits >> LAT_SHIFT);
    assign cmdVec[c].lastIdx = cfgR[STEP_LSB +: STEP_W];

    assign ctlVec[c]   = ctlR;
    assign cfgVec[c]   = cfgR;
    assign ienVec[c]   = ienR;
    assign ienLoVec[c] = ienR[0];
    assign staVec[c]   = staR;
  end

  // Per-sector completion mask of the decode channel.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= '0;
    end else if (cmdVec[CH_DEC].start && !evtVec[CH_DEC].busy) begin
      doneQ <= '0;
    end else begin
      doneQ <= (rdDone ? '0 : doneQ) |
               (evtVec[CH_DEC].stepDone ? (MAX_STEPS'(1) << evtVec[CH_DEC].stepIdx) : '0);
    end
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      case (busAddr)
        OFF_ENC_CTL:  busRdData = DATA_W'(ctlVec[CH_ENC]);
        OFF_ENC_CFG:  busRdData = cfgVec[CH_ENC];
        OFF_ENC_IDLE: busRdData = DATA_W'(!evtVec[CH_ENC].busy);
        OFF_ENC_IEN:  busRdData = DATA_W'(ienVec[CH_ENC]);
        OFF_ENC_STA:  busRdData = DATA_W'(staVec[CH_ENC]);
        OFF_DEC_CTL:  busRdData = DATA_W'(ctlVec[CH_DEC]);
        OFF_DEC_CFG:  busRdData = cfgVec[CH_DEC];
        OFF_DEC_IDLE: busRdData = DATA_W'(!evtVec[CH_DEC].busy);
        OFF_DEC_DONE: busRdData = DATA_W'(doneQ);
        OFF_DEC_IEN:  busRdData = DATA_W'(ienVec[CH_DEC]);
        OFF_DEC_STA:  busRdData = DATA_W'(staVec[CH_DEC]);
        default:      busRdData = '0;
      endcase
    end
  end

  assign irq = |(staVec & ienLoVec);
endmodule

// File: rtl/eccFront.sv
`timescale 1ns/1ps
module eccFront
  import eccFrontPkg::*;
#(
  parameter int NUM_STRENGTHS = 20,
  parameter int BASE_LAT      = 2,
  parameter int LAT_SHIFT     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  chanCmd_t [NUM_CH-1:0]         cmdVec;
  chanEvt_t [NUM_CH-1:0]         evtVec;
  logic [NUM_CH-1:0]             staVec;
  logic [NUM_CH-1:0]             ienLoVec;
  logic [NUM_CH-1:0][DATA_W-1:0] cfgVec;
  logic [NUM_CH-1:0]             chanBusy;
  logic [DATA_W-1:0]             encCfgQ;
  logic [DATA_W-1:0]             decCfgQ;

  eccRegCtrl #(
    .NUM_STRENGTHS(NUM_STRENGTHS),
    .BASE_LAT(BASE_LAT),
    .LAT_SHIFT(LAT_SHIFT)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irq(irq),
    .evtVec(evtVec), .cmdVec(cmdVec), .staVec(staVec),
    .ienLoVec(ienLoVec), .cfgVec(cfgVec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : gEng
    eccStepEngine uEng (
      .clk(clk), .rstN(rstN), .cmd(cmdVec[c]), .evt(evtVec[c])
    );
    assign chanBusy[c] = evtVec[c].busy;
  end

  assign encCfgQ = cfgVec[CH_ENC];
  assign decCfgQ = cfgVec[CH_DEC];
endmodule

// File: rtl/eccFrontChk.sv
`timescale 1ns/1ps
module eccFrontChk
  import eccFrontPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [NUM_CH-1:0] chanBusy,
  input logic [NUM_CH-1:0] staVec,
  input logic [DATA_W-1:0] encCfgQ,
  input logic [DATA_W-1:0] decCfgQ
);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_ENC_CTL && busWrData[0] && !chanBusy[CH_ENC]) |=> chanBusy[CH_ENC]);

  assert_stop_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_DEC_CTL && !busWrData[0]) |=> !chanBusy[CH_DEC]);

  assert_enc_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    chanBusy[CH_ENC] |=> $stable(encCfgQ));

  assert_dec_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    chanBusy[CH_DEC] |=> $stable(decCfgQ));

  assert_enc_sta_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(staVec[CH_ENC]) |-> $past(busRdEn && busAddr == OFF_ENC_STA));

  assert_dec_sta_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(staVec[CH_DEC]) |-> $past(busRdEn && (busAddr == OFF_DEC_STA || busAddr == OFF_DEC_DONE)));
endmodule

bind eccFront eccFrontChk uChk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busWrData(busWrData), .chanBusy(chanBusy),
  .staVec(staVec), .encCfgQ(encCfgQ), .decCfgQ(decCfgQ)
);

// File: tb/sim_eccFront.sv
`timescale 1ns/1ps
module sim_eccFront;
  localparam real CLK_PERIOD = 8.0;
  localparam logic [11:0] A_ECTL = 12'h000, A_ECFG = 12'h004, A_EIDLE = 12'h00C,
                          A_EIEN = 12'h080, A_ESTA = 12'h084,
                          A_DCTL = 12'h100, A_DCFG = 12'h104, A_DIDLE = 12'h10C,
                          A_DDONE = 12'h124, A_DIEN = 12'h200, A_DSTA = 12'h204;
  localparam logic [31:0] ENC_MASK = 32'h3FFF_073F;
  localparam logic [31:0] DEC_MASK = 32'hBFFF_373F;
  // {configuration word, expected cycles from start edge to idle}
  localparam logic [47:0] VECS [4] = '{
    {32'h0080_0203, 16'd12},
    {32'h0040_0020, 16'd3},
    {32'h03E8_010A, 16'd34},
    {32'h0000_0713, 16'd16}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  eccFront u0 (.clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
               .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(input int idx, input int mode, input int stepsM1, input int msg);
    return (32'(msg) << 16) | (32'(stepsM1) << 8) | (32'(mode) << 5) | 32'(idx);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] w);
    busAddr = a; busWrData = w; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] r);
    busAddr = a; busRdEn = 1'b1;
    #0.2 r = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] r);
    busAddr = a; busRdEn = 1'b1;
    #0.2 r = busRdData;
    busRdEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    peek(A_ECTL, d);  chk("R1 enc ctl", d, 0);
    peek(A_DCTL, d);  chk("R1 dec ctl", d, 0);
    peek(A_ECFG, d);  chk("R1 enc cfg", d, 0);
    peek(A_DCFG, d);  chk("R1 dec cfg", d, 0);
    peek(A_EIEN, d);  chk("R1 enc ien", d, 0);
    peek(A_DIEN, d);  chk("R1 dec ien", d, 0);
    peek(A_ESTA, d);  chk("R1 enc sta", d, 0);
    peek(A_DSTA, d);  chk("R1 dec sta", d, 0);
    peek(A_DDONE, d); chk("R1 done mask", d, 0);
    peek(A_EIDLE, d); chk("R1 enc idle", d, 1);
    peek(A_DIDLE, d); chk("R1 dec idle", d, 1);
    chk("R1 irq", 32'(irq), 0);
    tick(1);

    // R2 / R11: vector table on the encode channel, interrupts disabled
    for (int i = 0; i < 4; i++) begin
      logic [31:0] cfg;
      int t;
      cfg = VECS[i][47:16];
      t = int'(VECS[i][15:0]);
      busWrite(A_ECFG, cfg);
      peek(A_ECFG, d); chk("R4 vector cfg readback", d, cfg & ENC_MASK);
      busWrite(A_ECTL, 32'd1);
      tick(t - 1);
      peek(A_EIDLE, d); chk("R2 busy one cycle before end", d, 0);
      tick(1);
      peek(A_EIDLE, d); chk("R2 idle at end", d, 1);
      peek(A_ESTA, d);  chk("R11 no status without enable", d, 0);
      chk("R11 irq stays low", 32'(irq), 0);
      busWrite(A_ECTL, 32'd0);
    end

    // R4 field layout
    busWrite(A_DCFG, 32'hFFFF_FF13);
    peek(A_DCFG, d); chk("R4 dec cfg keeps decode fields", d, 32'hFFFF_FF13 & DEC_MASK);
    busWrite(A_ECFG, 32'hFFFF_FF13);
    peek(A_ECFG, d); chk("R4 enc cfg drops decode fields", d, 32'hFFFF_FF13 & ENC_MASK);

    // R5 invalid strength index
    busWrite(A_ECFG, mkCfg(20, 0, 0, 64));
    peek(A_ECFG, d); chk("R5 index 20 ignored", d, 32'hFFFF_FF13 & ENC_MASK);
    busWrite(A_DCFG, mkCfg(31, 0, 0, 64));
    peek(A_DCFG, d); chk("R5 index 31 ignored", d, 32'hFFFF_FF13 & DEC_MASK);

    // R6 write while busy, R3 stop
    busWrite(A_EIEN, 32'd1);
    busWrite(A_ECFG, mkCfg(2, 0, 1, 1000));        // lat 17, 2 steps
    busWrite(A_ECTL, 32'd1);
    busWrite(A_ECFG, mkCfg(5, 0, 0, 64));
    peek(A_ECFG, d); chk("R6 cfg write while busy ignored", d, mkCfg(2, 0, 1, 1000));
    busWrite(A_ECTL, 32'd0);
    peek(A_EIDLE, d); chk("R3 idle right after stop", d, 1);
    tick(40);
    peek(A_ESTA, d); chk("R3 no step event after stop", d, 0);
    chk("R3 irq low after stop", 32'(irq), 0);

    // R7 per-step decode interrupts, R9 clear, R10 mask
    busWrite(A_DIEN, 32'd1);
    busWrite(A_DCFG, mkCfg(3, 0, 2, 128));          // lat 4, 3 steps
    busWrite(A_DCTL, 32'd1);
    tick(4);
    chk("R7 irq after first step", 32'(irq), 1);
    busRead(A_DSTA, d); chk("R9 status read returns flag", d, 1);
    peek(A_DSTA, d); chk("R9 status cleared by read", d, 0);
    chk("R9 irq drops after read", 32'(irq), 0);
    tick(3);
    chk("R7 irq after second step", 32'(irq), 1);
    tick(4);
    busRead(A_DDONE, d); chk("R10 done mask all three sectors", d, 32'h7);
    peek(A_DDONE, d); chk("R10 mask cleared by read", d, 0);
    peek(A_DSTA, d); chk("R10 done read clears decode status", d, 0);
    chk("R10 irq low after done read", 32'(irq), 0);

    // R8 page mode
    busWrite(A_DIEN, 32'd3);
    busWrite(A_DCTL, 32'd1);
    tick(4);
    chk("R8 page mode no irq after step 0", 32'(irq), 0);
    tick(4);
    chk("R8 page mode no irq after step 1", 32'(irq), 0);
    tick(4);
    chk("R8 page mode irq after last step", 32'(irq), 1);
    busRead(A_DSTA, d); chk("R8 page status", d, 1);
    busRead(A_DDONE, d); chk("R8 mask still per sector", d, 32'h7);
    busWrite(A_DCFG, mkCfg(3, 1, 2, 128));          // mode bit 5 = 1
    busWrite(A_DCTL, 32'd1);
    tick(4);
    chk("R8 mode 1 ignores page select", 32'(irq), 1);
    tick(9);
    busRead(A_DSTA, d);
    busRead(A_DDONE, d);
    busWrite(A_DIEN, 32'd0);

    // R9 collision: read at the edge where the only step completes
    busWrite(A_EIEN, 32'd1);
    busWrite(A_ECFG, mkCfg(1, 0, 0, 128));          // lat 4, 1 step
    busWrite(A_ECTL, 32'd1);
    tick(3);
    busRead(A_ESTA, d); chk("R9 colliding read returns 0", d, 0);
    peek(A_ESTA, d); chk("R9 flag survives colliding read", d, 1);
    chk("R9 irq raised after collision", 32'(irq), 1);
    busRead(A_ESTA, d); chk("R9 second read returns flag", d, 1);
    peek(A_ESTA, d); chk("R9 flag cleared after second read", d, 0);

    // R10 collision on the done mask
    busWrite(A_DCFG, mkCfg(1, 0, 0, 128));
    busWrite(A_DCTL, 32'd1);
    tick(3);
    busRead(A_DDONE, d); chk("R10 colliding done read returns 0", d, 0);
    peek(A_DDONE, d); chk("R10 sector bit survives collision", d, 1);
    busRead(A_DDONE, d); chk("R10 second done read", d, 1);

    // R12 channel independence
    busWrite(A_ECFG, mkCfg(0, 0, 1, 1000));         // T = 34
    busWrite(A_DCFG, mkCfg(0, 0, 0, 64));           // T = 3
    busWrite(A_ECTL, 32'd1);
    busWrite(A_DCTL, 32'd1);
    tick(2);
    peek(A_DIDLE, d); chk("R12 decode busy while encode runs", d, 0);
    tick(1);
    peek(A_DIDLE, d); chk("R12 decode finished on its own", d, 1);
    peek(A_EIDLE, d); chk("R12 encode still busy", d, 0);
    busWrite(A_ECTL, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule